// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block guards against a runaway program. A down counter, `CNT_W` bits wide, is refilled to all ones whenever software writes the refresh strobe. It then steps down once per counting tick. A tick comes either from a prescaler that divides the CPU clock or, when selected, directly from an on-chip oscillator enable. If software stops refreshing, the counter passes zero and underflows. A set-only action bit then picks one of two responses: a one-cycle interrupt request, or a sticky active-low system reset.

The block is idle after reset. Neither the prescaler nor the counter moves until the first refresh write. The divide ratio follows the CPU clock source. The sub-clock forces a ratio of `DIV_SUB`. Otherwise a select bit chooses `DIV_LO` or `DIV_HI`. A freeze input models stop, wait and hold states: while it is high, the prescaler and the counter keep their values, and they continue from those values when it falls. With defaults, a 16 MHz clock and a ratio of 16 give a period of 16 × 32768 / 16 MHz, about 32.8 ms.

Top module: `wdt_timer`

## Requirements
- R1: The counter starts at all ones and decrements once per counting tick. The tick that finds it at zero is the underflow, so a timeout is 2^CNT_W ticks after a reload.
- R2: A refresh write reloads the counter to all ones and wins over a tick in the same cycle. It does not clear the prescaler phase. If the write is captured at edge Rw, then with ratio D the ticks fall on edges that are multiples of D counted from the first refresh, and the underflow comes 2^CNT_W − 1 ticks after the first tick edge beyond Rw.
- R3: After reset and before the first refresh write, the prescaler and the counter do not run: no interrupt and no reset occur however long the block waits.
- R4: With `sub_clk_sel`=0 and `alt_src_sel`=0, the prescaler divides by `DIV_LO` (16) when `div_hi_sel`=0 and by `DIV_HI` (128) when `div_hi_sel`=1.
- R5: With `sub_clk_sel`=1 and `alt_src_sel`=0, the ratio is `DIV_SUB` (2) whatever `div_hi_sel` holds.
- R6: With `alt_src_sel`=1, the counter takes one tick per cycle in which `alt_src_tick` is high. This ignores `sub_clk_sel` and `div_hi_sel`.
- R7: In interrupt mode (action bit 0), `irq_pulse` is high for exactly the one cycle after the underflow edge. The counter reloads and runs on, so the next pulse follows 2^CNT_W ticks later.
- R8: In reset mode (action bit 1), `sys_rst_n` goes low in the cycle after the underflow edge. It stays low until `rst_n` is asserted, and `irq_pulse` stays low.
- R9: A write with `mode_we`=1 and `mode_wdata`=1 sets the action bit. A write of 0 has no effect. Only `rst_n` clears the bit.
- R10: While `freeze` is high, the prescaler and the counter hold. Each frozen cycle delays the timeout by exactly one cycle.
- R11: `rst_n` low clears the prescaler, the action bit and the started state, loads the counter with all ones, and drives `irq_pulse`=0 and `sys_rst_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low system reset |
| refresh_we | input | 1 | Refresh register write strobe; the first write also starts the block |
| mode_we | input | 1 | Action-bit write strobe |
| mode_wdata | input | 1 | Action-bit write data (1 = reset on timeout) |
| sub_clk_sel | input | 1 | CPU clock is the sub-clock |
| div_hi_sel | input | 1 | Select the high divide ratio for main-clock sources |
| alt_src_sel | input | 1 | Count on-chip oscillator ticks instead of the prescaler |
| alt_src_tick | input | 1 | On-chip oscillator tick enable |
| freeze | input | 1 | Low-power freeze (stop, wait or hold) |
| irq_pulse | output | 1 | One-cycle timeout interrupt request |
| sys_rst_n | output | 1 | Sticky active-low timeout reset |

## Verification
Each result is due a fixed number of edges after the edge that captures the refresh write. That edge is counted as zero. Ticks fall on edges D, 2D, and so on. The counter reaches zero after 2^CNT_W − 1 ticks. The underflow takes the 2^CNT_W-th tick. The registered action makes `irq_pulse` or a low `sys_rst_n` visible just after edge D·2^CNT_W. Frozen edges and a mid-run refresh move that edge by the amounts in R2 and R10. The bench sweeps every source and mode combination on a 4-bit counter. It drives inputs on falling edges and samples 1 ns after each rising edge, so it records the exact edge number of the first event and compares it with the computed figure.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   typedef enum logic {
      WDT_ACT_IRQ   = 1'b0,
      WDT_ACT_RESET = 1'b1
   } wdt_act_e;

   // ratio picked by clock source: sub-clock overrides the high/low select
   function automatic int unsigned wdt_ratio(input logic sub_sel, input logic hi_sel,
                                             input int unsigned div_sub,
                                             input int unsigned div_lo,
                                             input int unsigned div_hi);
      if (sub_sel)
         return div_sub;
      else if (hi_sel)
         return div_hi;
      else
         return div_lo;
   endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int unsigned DIV_LO  = 16,
   parameter int unsigned DIV_HI  = 128,
   parameter int unsigned DIV_SUB = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic sub_sel,
   input  logic hi_sel,
   output logic tick
);
   import wdt_pkg::*;

   localparam int unsigned PRE_W = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] last_val;
   logic             at_end;

   always_comb begin
      last_val = PRE_W'(wdt_ratio(sub_sel, hi_sel, DIV_SUB, DIV_LO, DIV_HI) - 1);
   end

   // >= so that a ratio drop mid-count wraps at once instead of running long
   assign at_end = (pre_q >= last_val);
   assign tick   = en & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (en) begin
         if (at_end)
            pre_q <= '0;
         else
            pre_q <= pre_q + PRE_W'(1);
      end
   end

   AST_PRE_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(pre_q)) else $error("prescaler moved while disabled"); // R10

endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             load,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             underflow
);
   localparam logic [CNT_W-1:0] RELOAD = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             step;

   assign step      = tick & active & ~load;
   assign underflow = step & (cnt_q == '0);
   assign cnt       = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= RELOAD;
      else if (load)
         cnt_q <= RELOAD;
      else if (step) begin
         if (cnt_q == '0)
            cnt_q <= RELOAD;
         else
            cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   AST_RELOAD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt_q == RELOAD) else $error("refresh did not reload"); // R2

   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && active && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1))
      else $error("counter did not step by one"); // R1

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !load) |=> $stable(cnt_q)) else $error("counter ran before start"); // R3

endmodule

// File: rtl/wdt_action.sv
module wdt_action (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_we,
   input  logic mode_wdata,
   input  logic underflow,
   output logic irq_pulse,
   output logic sys_rst_n
);
   import wdt_pkg::*;

   wdt_act_e mode_q;
   logic     irq_q;
   logic     fired_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= WDT_ACT_IRQ;
         irq_q   <= 1'b0;
         fired_q <= 1'b0;
      end else begin
         if (mode_we && mode_wdata)
            mode_q <= WDT_ACT_RESET;
         irq_q   <= underflow && (mode_q == WDT_ACT_IRQ);
         fired_q <= fired_q || (underflow && (mode_q == WDT_ACT_RESET));
      end
   end

   assign irq_pulse = irq_q;
   assign sys_rst_n = ~fired_q;

   AST_MODE_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == WDT_ACT_RESET) |=> (mode_q == WDT_ACT_RESET)) else $error("action bit cleared"); // R9

   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse) else $error("interrupt wider than one cycle"); // R7

   AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_rst_n |=> !sys_rst_n) else $error("timeout reset released"); // R8

   AST_NO_IRQ_IN_RST_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == WDT_ACT_RESET) |=> !irq_pulse) else $error("irq in reset mode"); // R8

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
   parameter int unsigned CNT_W       = 15,
   parameter int unsigned DIV_LO      = 16,
   parameter int unsigned DIV_HI      = 128,
   parameter int unsigned DIV_SUB     = 2,
   parameter bit          HAS_ALT_SRC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic refresh_we,
   input  logic mode_we,
   input  logic mode_wdata,
   input  logic sub_clk_sel,
   input  logic div_hi_sel,
   input  logic alt_src_sel,
   input  logic alt_src_tick,
   input  logic freeze,
   output logic irq_pulse,
   output logic sys_rst_n
);

   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("wdt_timer: CNT_W must be at least 2");
   end
   if (DIV_LO < 1 || DIV_SUB < 1) begin : g_bad_div_min
      $error("wdt_timer: divide ratios must be at least 1");
   end
   if (DIV_HI < DIV_LO || DIV_HI < DIV_SUB) begin : g_bad_div_max
      $error("wdt_timer: DIV_HI must be the largest ratio");
   end

   logic             active_q;
   logic             run;
   logic             use_alt;
   logic             pre_tick;
   logic             cnt_tick;
   logic             underflow;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         active_q <= 1'b0;
      else if (refresh_we)
         active_q <= 1'b1;
   end

   assign run = active_q & ~freeze;

   if (HAS_ALT_SRC) begin : g_alt_src
      assign use_alt  = alt_src_sel;
      assign cnt_tick = use_alt ? (run & alt_src_tick) : pre_tick;
   end else begin : g_no_alt_src
      assign use_alt  = 1'b0;
      assign cnt_tick = pre_tick;
   end

   wdt_prescaler #(
      .DIV_LO (DIV_LO),
      .DIV_HI (DIV_HI),
      .DIV_SUB(DIV_SUB)
   ) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (run & ~use_alt),
      .sub_sel(sub_clk_sel),
      .hi_sel (div_hi_sel),
      .tick   (pre_tick)
   );

   wdt_downcount #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active_q),
      .load     (refresh_we),
      .tick     (cnt_tick),
      .cnt      (cnt),
      .underflow(underflow)
   );

   wdt_action u_act (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_we   (mode_we),
      .mode_wdata(mode_wdata),
      .underflow (underflow),
      .irq_pulse (irq_pulse),
      .sys_rst_n (sys_rst_n)
   );

   AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !refresh_we) |=> $stable(cnt)) else $error("counter moved while frozen"); // R10

   AST_NO_EVENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |=> (!irq_pulse && sys_rst_n)) else $error("event before start"); // R3

endmodule

// File: tb/wdt_timer_test.sv
`timescale 1ns/1ps
module wdt_timer_test;

   localparam int CW   = 4;
   localparam int TOUT = 1 << CW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic refresh_we = 1'b0;
   logic mode_we = 1'b0;
   logic mode_wdata = 1'b0;
   logic sub_clk_sel = 1'b0;
   logic div_hi_sel = 1'b0;
   logic alt_src_sel = 1'b0;
   logic alt_src_tick = 1'b1;
   logic freeze = 1'b0;
   logic irq_pulse;
   logic sys_rst_n;

   int vectors = 0;
   int misses = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wdt_timer #(.CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .refresh_we(refresh_we), .mode_we(mode_we),
      .mode_wdata(mode_wdata), .sub_clk_sel(sub_clk_sel), .div_hi_sel(div_hi_sel),
      .alt_src_sel(alt_src_sel), .alt_src_tick(alt_src_tick), .freeze(freeze),
      .irq_pulse(irq_pulse), .sys_rst_n(sys_rst_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      refresh_we = 1'b0; mode_we = 1'b0; freeze = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(irq_pulse == 1'b0 && sys_rst_n == 1'b1, "R11 reset state",
            {30'd0, irq_pulse, sys_rst_n}, 1);
   endtask

   task automatic write_mode(input logic v);
      @(negedge clk);
      mode_we = 1'b1; mode_wdata = v;
      @(negedge clk);
      mode_we = 1'b0; mode_wdata = 1'b0;
   endtask

   // refresh captured at the next rising edge: that edge is number zero
   task automatic refresh_now();
      @(negedge clk);
      refresh_we = 1'b1;
      @(posedge clk);
   endtask

   // counts edges from the last edge seen; returns edge of first event
   task automatic watch(input bit rmode, input int limit, input int frz_at,
                        input int frz_len, input int ref_at, output int hit);
      int n = 0;
      hit = -1;
      while (n < limit) begin
         @(negedge clk);
         refresh_we = (n == ref_at);
         freeze = (n >= frz_at) && (n < frz_at + frz_len);
         @(posedge clk);
         n++;
         #1;
         if (rmode ? !sys_rst_n : irq_pulse) begin
            hit = n;
            break;
         end
      end
      @(negedge clk);
      refresh_we = 1'b0;
      freeze = 1'b0;
   endtask

   function automatic int ratio(input bit alt, input bit sub, input bit hi);
      if (alt) return 1;
      if (sub) return 2;
      return hi ? 128 : 16;
   endfunction

   initial begin
      #(200000 * 8);
      if (!done) begin
         misses++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      int hit;
      int d;
      int expn;

      // R3: no start without refresh
      do_reset();
      div_hi_sel = 1'b0;
      begin
         int bad = 0;
         for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            if (irq_pulse || !sys_rst_n) bad++;
         end
         check(bad == 0, "R3 idle before first refresh", bad, 0);
      end

      // sweep of every source select and action mode (R1 R4 R5 R6 R7 R8)
      for (int cfg = 0; cfg < 16; cfg++) begin
         bit a = cfg[0];
         bit s = cfg[1];
         bit h = cfg[2];
         bit m = cfg[3];
         alt_src_sel = a; sub_clk_sel = s; div_hi_sel = h;
         do_reset();
         if (m) write_mode(1'b1);
         d = ratio(a, s, h);
         expn = d * TOUT;
         refresh_now();
         watch(m, expn + 10, -1, 0, -1, hit);
         if (a)
            check(hit == expn, "R6 alt source period", hit, expn);
         else if (s)
            check(hit == expn, "R5 sub-clock ratio 2", hit, expn);
         else
            check(hit == expn, "R4 main-clock ratio", hit, expn);
         if (m) begin
            int low = 0;
            for (int i = 0; i < 6; i++) begin
               @(posedge clk); #1;
               if (!sys_rst_n && !irq_pulse) low++;
            end
            check(low == 6, "R8 reset held low", low, 6);
         end else begin
            // pulse already seen; next one a full period after the underflow edge
            watch(1'b0, expn + 10, -1, 0, -1, hit);
            check(hit == expn - 1, "R7 single pulse and rerun", hit, expn - 1);
         end
      end

      // R1: four-bit counter, ratio 16, default select
      alt_src_sel = 1'b0; sub_clk_sel = 1'b0; div_hi_sel = 1'b0;
      do_reset();
      refresh_now();
      watch(1'b0, 400, -1, 0, -1, hit);
      check(hit == 16 * TOUT, "R1 timeout after 2^W ticks", hit, 16 * TOUT);

      // R10: freeze for 37 edges mid-run
      do_reset();
      refresh_now();
      watch(1'b0, 400, 40, 37, -1, hit);
      check(hit == 16 * TOUT + 37, "R10 freeze delays timeout", hit, 16 * TOUT + 37);

      // R10 on alternate source
      alt_src_sel = 1'b1;
      do_reset();
      refresh_now();
      watch(1'b0, 100, 5, 9, -1, hit);
      check(hit == TOUT + 9, "R10 freeze alt source", hit, TOUT + 9);
      alt_src_sel = 1'b0;

      // R2: refresh captured at edge 101; prescaler phase kept
      do_reset();
      refresh_now();
      watch(1'b0, 600, -1, 0, 100, hit);
      expn = (101 / 16 + 1) * 16 + (TOUT - 1) * 16;
      check(hit == expn, "R2 refresh keeps prescaler phase", hit, expn);

      // R9: writing 0 after 1 leaves reset mode
      do_reset();
      write_mode(1'b1);
      write_mode(1'b0);
      refresh_now();
      watch(1'b1, 300, -1, 0, -1, hit);
      check(hit == 16 * TOUT, "R9 clear write ignored", hit, 16 * TOUT);

      // R9: a 0 write alone keeps interrupt mode
      do_reset();
      write_mode(1'b0);
      refresh_now();
      watch(1'b0, 300, -1, 0, -1, hit);
      check(hit == 16 * TOUT && sys_rst_n, "R9 interrupt mode kept", hit, 16 * TOUT);

      // R11: reset releases the sticky output
      do_reset();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule